// File: doc/BRIEF.md
# Sleep-State Power Sequencer

This block is a hardware finite-state machine that moves a platform between its power states: mechanical off, soft off (S5), suspend-to-RAM (S3) and fully on (S0). It also runs the timed transition steps between them. It reads power-good flags from the standby and main rail groups, two active-low sleep requests from the chipset, and a platform-reset indication. From these it drives the suspend regulator enable, the resume reset, the memory, 5 V, 3.3 V and CPU-core rail enables, the system and core power-good outputs, a CPU throttle line and a power-button press output.

Every transition is a fixed sequence with delays measured in clock ticks, derived from a ticks-per-millisecond parameter. Each wait for a rail is bounded by a timeout parameter. A failed wait forces a shutdown, which drops system power-good and asserts resume reset, and the machine then falls back to a lower state. If the platform reset does not release within its window on the way up to S0, the machine arms a restart. The next descent through S5 then waits, presses the power button and climbs again from the off-to-S5 step. A fault input makes the next platform-reset check fail once, so the recovery path can be exercised on purpose.

Top module: `pwrseq`

## Requirements
- R1: After reset the machine is in OFF and every output is low. `state_oh` is one-hot, with bit n set in state n: 0 OFF, 1 up-wait, 2 regulator-wait, 3 resume-settle, 4 S5, 5 standby-wait, 6 memory-wait, 7 S3, 8 5V-lead, 9 main-wait, 10 core-settle, 11 reset-poll, 12 S0, 13 pgood-guard, 14 rail-off, 15 restart-wait, 16 button-press.
- R2: A `start_req` in OFF enters state 1. After 10 ms, `en_susp_vr` rises. Once `pg_standby` is high, `resume_rst_n` rises and state 3 is held for 10 ms before S5.
- R3: If `pg_standby` stays low for RAIL_TMO_TICKS in state 2, the machine returns to OFF with the regulator off and a forced shutdown. A forced shutdown always means `sys_pgood` low and `resume_rst_n` low.
- R4: In S5, a high `sleep4_req_n` starts the climb. The machine waits for `pg_standby`, raises `en_mem`, waits for `pg_standby` again and enters S3. A timeout in either wait goes to OFF with a forced shutdown and the regulator off.
- R5: In S3, a high `sleep3_req_n` raises `en_5v` and, 3 ms later, `en_3v3`. Once `pg_standby` and `pg_main` are both high, `en_core` rises. After 15 ms, `sys_pgood` and `core_pgood` rise together, and `cpu_throttle` takes the level of `throttle_req`.
- R6: A main-rail wait that times out drops `en_5v` and `en_3v3`, forces shutdown and returns to S3.
- R7: In the reset-poll state, the machine enters S0 as soon as `plt_rst` is low and no fault is armed. Otherwise, after 50 ms it enters S0 with a forced shutdown and a pending restart. A pulse on `fault_plt` arms exactly one such failure.
- R8: In S0, loss of either rail group forces shutdown and starts the descent to S3. A low `sleep3_req_n` starts the same descent without forcing shutdown. Rail loss takes priority.
- R9: The descent clears both power-goods. GUARD_TICKS later it drops `en_core` and `cpu_throttle`. 7 ms after that it drops `en_3v3`, and it drops `en_5v` only when `usb_keep_s3` is low.
- R10: In S3, loss of `pg_standby` forces shutdown and descends. A low `sleep4_req_n` also descends. A high `sleep3_req_n` climbs. They are checked in that order.
- R11: The descent from S3 drops `en_5v` and `en_mem`. With no restart pending, it enters S5 when `pause_s5` is high. When `pause_s5` is low it enters OFF, with resume reset asserted and the regulator off.
- R12: With a restart pending, the descent clears the flag and waits 100 ms. It then raises `pwrbtn_press` for PBTN_TICKS and re-enters state 1.
- R13: While in S0, `cpu_throttle` follows `throttle_req` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start_req | input | 1 | request to leave OFF |
| pg_standby | input | 1 | standby rails good (synchronized) |
| pg_main | input | 1 | main rails good (synchronized) |
| sleep3_req_n | input | 1 | active-low suspend request |
| sleep4_req_n | input | 1 | active-low soft-off request |
| plt_rst | input | 1 | platform reset still asserted |
| throttle_req | input | 1 | desired CPU throttle level |
| usb_keep_s3 | input | 1 | keep 5 V up in S3 |
| pause_s5 | input | 1 | stop in S5 on shutdown |
| fault_plt | input | 1 | arm one platform-reset failure |
| en_susp_vr | output | 1 | suspend regulator enable |
| resume_rst_n | output | 1 | resume reset, active low |
| en_mem | output | 1 | memory rail enable |
| en_5v | output | 1 | 5 V rail enable |
| en_3v3 | output | 1 | 3.3 V rail enable |
| en_core | output | 1 | CPU-core supply enable |
| sys_pgood | output | 1 | system power-good |
| core_pgood | output | 1 | core power-good |
| cpu_throttle | output | 1 | CPU throttle line |
| pwrbtn_press | output | 1 | power-button press pulse |
| state_oh | output | 17 | one-hot state, bit order as in R1 |

## Verification
The first pattern is a clean power-up with every rail ready in advance. It pins the exact tick count of each timed step and shows that rail waits cost one cycle when the rail is already good. A second cycle injects a reset-poll fault, which separates the normal entry to S0 from the timeout, and then follows the restart through the button pulse into a regulator timeout. Later cycles withhold the main rails to reach the S3-side timeout and drop `pause_s5` to take the direct path to OFF. The last cycle removes rails and the suspend request together in S0, so the bench can tell which of the two takes priority from whether resume reset falls. `usb_keep_s3` is toggled between descents to show its effect on the 5 V rail.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [4:0] {
        ST_OFF      = 5'd0,
        ST_UP_WAIT  = 5'd1,
        ST_VR_WAIT  = 5'd2,
        ST_RSM_SET  = 5'd3,
        ST_SOFF     = 5'd4,
        ST_SB_WAIT  = 5'd5,
        ST_MEM_WAIT = 5'd6,
        ST_SUSP     = 5'd7,
        ST_V5_LEAD  = 5'd8,
        ST_MAIN_WT  = 5'd9,
        ST_CORE_SET = 5'd10,
        ST_PLT_POLL = 5'd11,
        ST_ON       = 5'd12,
        ST_PG_GUARD = 5'd13,
        ST_RAIL_OFF = 5'd14,
        ST_RST_WAIT = 5'd15,
        ST_BTN      = 5'd16
    } pstate_e;

    localparam int NUM_ST = 17;

    typedef struct packed {
        logic vr;
        logic rsm_n;
        logic mem;
        logic v5;
        logic v33;
        logic core;
        logic sys_pg;
        logic core_pg;
        logic hot;
        logic btn;
    } pwr_ctl_t;

    localparam pwr_ctl_t CTL_ALL_OFF = '0;

    function automatic pwr_ctl_t force_down(pwr_ctl_t c);
        pwr_ctl_t r;
        r        = c;
        r.sys_pg = 1'b0;
        r.rsm_n  = 1'b0;
        return r;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwrseq_dwell.sv
module pwrseq_dwell #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != {CW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwrseq_cond.sv
module pwrseq_cond (
    input  logic clk,
    input  logic rst,
    input  logic pg_standby,
    input  logic pg_main,
    input  logic fault_plt,
    input  logic fault_used,
    output logic s3_ok,
    output logic s0_ok,
    output logic fault_arm
);
    assign s3_ok = pg_standby;
    assign s0_ok = pg_standby && pg_main;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_arm <= 1'b0;
        end else if (fault_plt) begin
            fault_arm <= 1'b1;
        end else if (fault_used) begin
            fault_arm <= 1'b0;
        end
    end

    // R7
    fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_used && !fault_plt) |=> !fault_arm);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int CW         = 12,
    parameter int T_UP       = 10,
    parameter int T_RSM      = 10,
    parameter int T_V5_LEAD  = 3,
    parameter int T_CORE     = 15,
    parameter int T_PLT      = 50,
    parameter int T_RAIL_OFF = 7,
    parameter int T_RESTART  = 100,
    parameter int T_TMO      = 20,
    parameter int T_GUARD    = 1,
    parameter int T_BTN      = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic          start_req,
    input  logic          s3_ok,
    input  logic          s0_ok,
    input  logic          sleep3_req_n,
    input  logic          sleep4_req_n,
    input  logic          plt_rst,
    input  logic          throttle_req,
    input  logic          usb_keep_s3,
    input  logic          pause_s5,
    input  logic          fault_arm,
    output pstate_e       st_q,
    output pwr_ctl_t      ctl_q,
    output logic          st_chg,
    output logic          fault_used
);
    pstate_e  st_d;
    pwr_ctl_t ctl_d;
    logic     restart_q, restart_d;
    logic     go_down;

    localparam logic [CW-1:0] L_UP   = CW'(T_UP - 1);
    localparam logic [CW-1:0] L_RSM  = CW'(T_RSM - 1);
    localparam logic [CW-1:0] L_V5   = CW'(T_V5_LEAD - 1);
    localparam logic [CW-1:0] L_CORE = CW'(T_CORE - 1);
    localparam logic [CW-1:0] L_PLT  = CW'(T_PLT - 1);
    localparam logic [CW-1:0] L_ROFF = CW'(T_RAIL_OFF - 1);
    localparam logic [CW-1:0] L_RST  = CW'(T_RESTART - 1);
    localparam logic [CW-1:0] L_TMO  = CW'(T_TMO - 1);
    localparam logic [CW-1:0] L_GRD  = CW'(T_GUARD - 1);
    localparam logic [CW-1:0] L_BTN  = CW'(T_BTN - 1);

    always_comb begin
        st_d       = st_q;
        ctl_d      = ctl_q;
        restart_d  = restart_q;
        fault_used = 1'b0;
        go_down    = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                if (start_req) st_d = ST_UP_WAIT;
            end
            ST_UP_WAIT: begin
                if (cnt == L_UP) begin
                    st_d     = ST_VR_WAIT;
                    ctl_d.vr = 1'b1;
                end
            end
            ST_VR_WAIT: begin
                if (s3_ok) begin
                    st_d        = ST_RSM_SET;
                    ctl_d.rsm_n = 1'b1;
                end else if (cnt == L_TMO) begin
                    st_d     = ST_OFF;
                    ctl_d    = force_down(ctl_q);
                    ctl_d.vr = 1'b0;
                end
            end
            ST_RSM_SET: begin
                if (cnt == L_RSM) st_d = ST_SOFF;
            end
            ST_SOFF: begin
                if (sleep4_req_n) st_d = ST_SB_WAIT;
            end
            ST_SB_WAIT, ST_MEM_WAIT: begin
                if (s3_ok) begin
                    if (st_q == ST_SB_WAIT) begin
                        st_d      = ST_MEM_WAIT;
                        ctl_d.mem = 1'b1;
                    end else begin
                        st_d = ST_SUSP;
                    end
                end else if (cnt == L_TMO) begin
                    st_d     = ST_OFF;
                    ctl_d    = force_down(ctl_q);
                    ctl_d.vr = 1'b0;
                end
            end
            ST_SUSP: begin
                if (!s3_ok) begin
                    ctl_d   = force_down(ctl_q);
                    go_down = 1'b1;
                end else if (!sleep4_req_n) begin
                    go_down = 1'b1;
                end else if (sleep3_req_n) begin
                    st_d     = ST_V5_LEAD;
                    ctl_d.v5 = 1'b1;
                end
                if (go_down) begin
                    ctl_d.v5  = 1'b0;
                    ctl_d.mem = 1'b0;
                    if (restart_q) begin
                        st_d      = ST_RST_WAIT;
                        restart_d = 1'b0;
                    end else if (pause_s5) begin
                        st_d = ST_SOFF;
                    end else begin
                        st_d        = ST_OFF;
                        ctl_d.rsm_n = 1'b0;
                        ctl_d.vr    = 1'b0;
                    end
                end
            end
            ST_V5_LEAD: begin
                if (cnt == L_V5) begin
                    st_d      = ST_MAIN_WT;
                    ctl_d.v33 = 1'b1;
                end
            end
            ST_MAIN_WT: begin
                if (s0_ok) begin
                    st_d       = ST_CORE_SET;
                    ctl_d.core = 1'b1;
                end else if (cnt == L_TMO) begin
                    st_d      = ST_SUSP;
                    ctl_d     = force_down(ctl_q);
                    ctl_d.v5  = 1'b0;
                    ctl_d.v33 = 1'b0;
                end
            end
            ST_CORE_SET: begin
                if (cnt == L_CORE) begin
                    st_d          = ST_PLT_POLL;
                    ctl_d.sys_pg  = 1'b1;
                    ctl_d.core_pg = 1'b1;
                    ctl_d.hot     = throttle_req;
                end
            end
            ST_PLT_POLL: begin
                if (!plt_rst && !fault_arm) begin
                    st_d = ST_ON;
                end else if (cnt == L_PLT) begin
                    st_d       = ST_ON;
                    ctl_d      = force_down(ctl_q);
                    restart_d  = 1'b1;
                    fault_used = 1'b1;
                end
            end
            ST_ON: begin
                ctl_d.hot = throttle_req;
                if (!s0_ok) begin
                    st_d          = ST_PG_GUARD;
                    ctl_d         = force_down(ctl_d);
                    ctl_d.core_pg = 1'b0;
                end else if (!sleep3_req_n) begin
                    st_d          = ST_PG_GUARD;
                    ctl_d.sys_pg  = 1'b0;
                    ctl_d.core_pg = 1'b0;
                end
            end
            ST_PG_GUARD: begin
                if (cnt == L_GRD) begin
                    st_d       = ST_RAIL_OFF;
                    ctl_d.core = 1'b0;
                    ctl_d.hot  = 1'b0;
                end
            end
            ST_RAIL_OFF: begin
                if (cnt == L_ROFF) begin
                    st_d      = ST_SUSP;
                    ctl_d.v33 = 1'b0;
                    if (!usb_keep_s3) ctl_d.v5 = 1'b0;
                end
            end
            ST_RST_WAIT: begin
                if (cnt == L_RST) begin
                    st_d      = ST_BTN;
                    ctl_d.btn = 1'b1;
                end
            end
            ST_BTN: begin
                if (cnt == L_BTN) begin
                    st_d      = ST_UP_WAIT;
                    ctl_d.btn = 1'b0;
                end
            end
            default: begin
                st_d  = ST_OFF;
                ctl_d = CTL_ALL_OFF;
            end
        endcase
    end

    assign st_chg = (st_d != st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_OFF;
            ctl_q     <= CTL_ALL_OFF;
            restart_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            ctl_q     <= ctl_d;
            restart_q <= restart_d;
        end
    end

    // R2
    rsm_needs_vr_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.rsm_n |-> ctl_q.vr);
    // R5
    pgood_rails_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.core_pg) |-> (ctl_q.core && ctl_q.v5 && ctl_q.v33));
    // R9
    core_off_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.core) |-> (!ctl_q.sys_pg && !ctl_q.core_pg));
    // R8
    s0_rail_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ON && !s0_ok) |=> (st_q == ST_PG_GUARD && !ctl_q.rsm_n));
    // R7
    plt_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PLT_POLL && !plt_rst && !fault_arm) |=> (st_q == ST_ON));
    // R12
    btn_mem_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.btn) |-> (!ctl_q.mem && !ctl_q.v5));
endmodule

// File: rtl/pwrseq.sv
module pwrseq
    import pwrseq_pkg::*;
#(
    parameter int TICKS_PER_MS   = 1000,
    parameter int RAIL_TMO_TICKS = 10000,
    parameter int GUARD_TICKS    = 1,
    parameter int PBTN_TICKS     = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              pg_standby,
    input  logic              pg_main,
    input  logic              sleep3_req_n,
    input  logic              sleep4_req_n,
    input  logic              plt_rst,
    input  logic              throttle_req,
    input  logic              usb_keep_s3,
    input  logic              pause_s5,
    input  logic              fault_plt,
    output logic              en_susp_vr,
    output logic              resume_rst_n,
    output logic              en_mem,
    output logic              en_5v,
    output logic              en_3v3,
    output logic              en_core,
    output logic              sys_pgood,
    output logic              core_pgood,
    output logic              cpu_throttle,
    output logic              pwrbtn_press,
    output logic [NUM_ST-1:0] state_oh
);
    localparam int T_UP       = 10 * TICKS_PER_MS;
    localparam int T_RSM      = 10 * TICKS_PER_MS;
    localparam int T_V5_LEAD  = 3 * TICKS_PER_MS;
    localparam int T_CORE     = 15 * TICKS_PER_MS;
    localparam int T_PLT      = 50 * TICKS_PER_MS;
    localparam int T_RAIL_OFF = 7 * TICKS_PER_MS;
    localparam int T_RESTART  = 100 * TICKS_PER_MS;
    localparam int T_MAX      = imax(imax(T_RESTART, RAIL_TMO_TICKS),
                                     imax(PBTN_TICKS, GUARD_TICKS));
    localparam int CW         = $clog2(T_MAX + 1);

    logic          s3_ok, s0_ok, fault_arm, fault_used, st_chg;
    logic [CW-1:0] cnt;
    pstate_e       st_q;
    pwr_ctl_t      ctl_q;

    pwrseq_cond u_cond (
        .clk        (clk),
        .rst        (rst),
        .pg_standby (pg_standby),
        .pg_main    (pg_main),
        .fault_plt  (fault_plt),
        .fault_used (fault_used),
        .s3_ok      (s3_ok),
        .s0_ok      (s0_ok),
        .fault_arm  (fault_arm)
    );

    pwrseq_dwell #(.CW(CW)) u_dwell (
        .clk (clk),
        .rst (rst),
        .clr (st_chg),
        .cnt (cnt)
    );

    pwrseq_fsm #(
        .CW(CW), .T_UP(T_UP), .T_RSM(T_RSM), .T_V5_LEAD(T_V5_LEAD),
        .T_CORE(T_CORE), .T_PLT(T_PLT), .T_RAIL_OFF(T_RAIL_OFF),
        .T_RESTART(T_RESTART), .T_TMO(RAIL_TMO_TICKS),
        .T_GUARD(GUARD_TICKS), .T_BTN(PBTN_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cnt          (cnt),
        .start_req    (start_req),
        .s3_ok        (s3_ok),
        .s0_ok        (s0_ok),
        .sleep3_req_n (sleep3_req_n),
        .sleep4_req_n (sleep4_req_n),
        .plt_rst      (plt_rst),
        .throttle_req (throttle_req),
        .usb_keep_s3  (usb_keep_s3),
        .pause_s5     (pause_s5),
        .fault_arm    (fault_arm),
        .st_q         (st_q),
        .ctl_q        (ctl_q),
        .st_chg       (st_chg),
        .fault_used   (fault_used)
    );

    assign en_susp_vr   = ctl_q.vr;
    assign resume_rst_n = ctl_q.rsm_n;
    assign en_mem       = ctl_q.mem;
    assign en_5v        = ctl_q.v5;
    assign en_3v3       = ctl_q.v33;
    assign en_core      = ctl_q.core;
    assign sys_pgood    = ctl_q.sys_pg;
    assign core_pgood   = ctl_q.core_pg;
    assign cpu_throttle = ctl_q.hot;
    assign pwrbtn_press = ctl_q.btn;

    for (genvar gi = 0; gi < NUM_ST; gi++) begin : g_oh
        assign state_oh[gi] = (int'(st_q) == gi);
    end

    // R1
    state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(state_oh) && (state_oh != '0));
    // R2
    dwell_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != $past(st_q)) |-> (cnt == '0));
endmodule

// File: tb/pwrseq_tb.sv
module pwrseq_tb;
    import pwrseq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 0, pg_standby = 0, pg_main = 0, sleep3_req_n = 0;
    logic sleep4_req_n = 0, plt_rst = 1, throttle_req = 0, usb_keep_s3 = 0;
    logic pause_s5 = 1, fault_plt = 0;
    logic en_susp_vr, resume_rst_n, en_mem, en_5v, en_3v3, en_core;
    logic sys_pgood, core_pgood, cpu_throttle, pwrbtn_press;
    logic [NUM_ST-1:0] state_oh;

    always #2 clk = ~clk;

    pwrseq #(.TICKS_PER_MS(4), .RAIL_TMO_TICKS(20), .GUARD_TICKS(2), .PBTN_TICKS(3)) u_dut (
        .clk(clk), .rst(rst), .start_req(start_req), .pg_standby(pg_standby),
        .pg_main(pg_main), .sleep3_req_n(sleep3_req_n), .sleep4_req_n(sleep4_req_n),
        .plt_rst(plt_rst), .throttle_req(throttle_req), .usb_keep_s3(usb_keep_s3),
        .pause_s5(pause_s5), .fault_plt(fault_plt), .en_susp_vr(en_susp_vr),
        .resume_rst_n(resume_rst_n), .en_mem(en_mem), .en_5v(en_5v), .en_3v3(en_3v3),
        .en_core(en_core), .sys_pgood(sys_pgood), .core_pgood(core_pgood),
        .cpu_throttle(cpu_throttle), .pwrbtn_press(pwrbtn_press), .state_oh(state_oh)
    );

    localparam logic [9:0] B_VR = 10'h200, B_RSM = 10'h100, B_MEM = 10'h080,
        B_V5 = 10'h040, B_V33 = 10'h020, B_CORE = 10'h010, B_SYS = 10'h008,
        B_CPG = 10'h004, B_HOT = 10'h002, B_PB = 10'h001;

    wire [9:0] outs = {en_susp_vr, resume_rst_n, en_mem, en_5v, en_3v3, en_core,
                       sys_pgood, core_pgood, cpu_throttle, pwrbtn_press};

    typedef struct {
        int         st;
        logic [9:0] o;
        int         dw;
        string      req;
    } exp_t;

    exp_t       q[$];
    logic [9:0] e = '0;
    int         n_chk = 0, n_bad = 0;
    int         dwell = 0;
    int         cyc = 0;
    logic [NUM_ST-1:0] prev_oh = 17'h1;

    task automatic push(input int st, input int dw, input string req);
        exp_t x;
        x.st = st; x.o = e; x.dw = dw; x.req = req;
        q.push_back(x);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_st(input int st);
        do @(negedge clk); while (!state_oh[st]);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: compares each state change against the scoreboard queue
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (state_oh != prev_oh) begin
                if (q.size() == 0) begin
                    check("unexpected transition", {15'd0, state_oh}, {15'd0, prev_oh});
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    check({x.req, " state"}, {15'd0, state_oh}, 32'd1 << x.st);
                    check({x.req, " outputs"}, {22'd0, outs}, {22'd0, x.o});
                    if (x.dw != 0) check({x.req, " dwell"}, dwell, x.dw);
                end
                dwell   = 1;
                prev_oh = state_oh;
            end else begin
                dwell++;
            end
        end
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset state", {15'd0, state_oh}, 32'd1);
        check("R1 reset outputs", {22'd0, outs}, 32'd0);

        // Phase A: clean power-up to S0 and back to S5
        pg_standby = 1;
        push(1, 0, "R2 leave OFF");
        e |= B_VR;  push(2, 40, "R2 regulator on after 10ms");
        e |= B_RSM; push(3, 1, "R2 resume release");
        push(4, 40, "R2 settle 10ms");
        pulse(start_req);
        wait_st(4);
        push(5, 0, "R4 climb start");
        e |= B_MEM; push(6, 1, "R4 memory rail");
        push(7, 1, "R4 enter S3");
        sleep4_req_n = 1;
        wait_st(7);
        throttle_req = 1; pg_main = 1; plt_rst = 1;
        e |= B_V5;  push(8, 0, "R5 5V first");
        e |= B_V33; push(9, 12, "R5 3V3 after 3ms");
        e |= B_CORE; push(10, 1, "R5 core enable");
        e |= B_SYS | B_CPG | B_HOT; push(11, 60, "R5 pgoods after 15ms");
        push(12, 0, "R7 reset released");
        sleep3_req_n = 1;
        wait_st(11);
        repeat (5) @(negedge clk);
        plt_rst = 0;
        wait_st(12);
        throttle_req = 0;
        repeat (2) @(negedge clk);
        check("R13 throttle low", {31'd0, cpu_throttle}, 0);
        throttle_req = 1;
        repeat (2) @(negedge clk);
        check("R13 throttle high", {31'd0, cpu_throttle}, 1);
        usb_keep_s3 = 1;
        e &= ~(B_SYS | B_CPG); push(13, 0, "R8 suspend request");
        e &= ~(B_CORE | B_HOT); push(14, 2, "R9 guard then core off");
        e &= ~B_V33; push(7, 28, "R9 3V3 off 5V kept");
        sleep3_req_n = 0;
        wait_st(7);
        e &= ~(B_V5 | B_MEM); push(4, 0, "R11 pause in S5");
        sleep4_req_n = 0;
        wait_st(4);

        // Phase B: injected reset-poll failure and restart
        usb_keep_s3 = 0;
        pulse(fault_plt);
        push(5, 0, "R4 climb");
        e |= B_MEM; push(6, 1, "R4 memory rail");
        push(7, 1, "R4 enter S3");
        sleep4_req_n = 1;
        wait_st(7);
        e |= B_V5;  push(8, 0, "R5 5V");
        e |= B_V33; push(9, 12, "R5 3V3");
        e |= B_CORE; push(10, 1, "R5 core");
        e |= B_SYS | B_CPG | B_HOT; push(11, 60, "R5 pgoods");
        e &= ~(B_SYS | B_RSM); push(12, 200, "R7 poll timeout 50ms");
        sleep3_req_n = 1;
        wait_st(12);
        e &= ~B_CPG; push(13, 0, "R8 descent");
        e &= ~(B_CORE | B_HOT); push(14, 2, "R9 core off");
        e &= ~(B_V33 | B_V5); push(7, 28, "R9 both rails off");
        sleep3_req_n = 0;
        wait_st(7);
        e &= ~B_MEM; push(15, 0, "R12 restart wait");
        e |= B_PB;   push(16, 400, "R12 button after 100ms");
        e &= ~B_PB;  push(1, 3, "R12 button released");
        sleep4_req_n = 0;
        wait_st(15);
        pg_standby = 0;
        push(2, 40, "R2 regulator step");
        e = '0; push(0, 20, "R3 regulator timeout");
        wait_st(0);

        // Phase C: main-rail timeout and direct path to OFF
        pg_standby = 1; pg_main = 0;
        push(1, 0, "R2 leave OFF");
        e |= B_VR;  push(2, 40, "R2 regulator");
        e |= B_RSM; push(3, 1, "R2 resume");
        push(4, 40, "R2 settle");
        pulse(start_req);
        wait_st(4);
        push(5, 0, "R4 climb");
        e |= B_MEM; push(6, 1, "R4 memory");
        push(7, 1, "R4 S3");
        sleep4_req_n = 1;
        wait_st(7);
        e |= B_V5;  push(8, 0, "R5 5V");
        e |= B_V33; push(9, 12, "R5 3V3");
        e &= ~(B_V5 | B_V33 | B_RSM); push(7, 20, "R6 main timeout");
        sleep3_req_n = 1;
        wait_st(8);
        sleep3_req_n = 0;
        wait_st(7);
        e = '0; push(0, 0, "R10 R11 standby loss to OFF");
        pause_s5 = 0; pg_standby = 0;
        wait_st(0);

        // Phase D: rail loss in S0 takes priority over suspend request
        pg_standby = 1; pg_main = 1; pause_s5 = 1; throttle_req = 0;
        push(1, 0, "R2 leave OFF");
        e |= B_VR;  push(2, 40, "R2 regulator");
        e |= B_RSM; push(3, 1, "R2 resume");
        push(4, 40, "R2 settle");
        push(5, 1, "R4 climb immediate");
        e |= B_MEM; push(6, 1, "R4 memory");
        push(7, 1, "R4 S3");
        pulse(start_req);
        wait_st(7);
        e |= B_V5;  push(8, 0, "R10 climb to S0");
        e |= B_V33; push(9, 12, "R5 3V3");
        e |= B_CORE; push(10, 1, "R5 core");
        e |= B_SYS | B_CPG; push(11, 60, "R5 pgoods no throttle");
        push(12, 1, "R7 fault consumed once");
        sleep3_req_n = 1;
        wait_st(12);
        e &= ~(B_SYS | B_CPG | B_RSM); push(13, 0, "R8 rail loss forces shutdown");
        e &= ~B_CORE; push(14, 2, "R9 core off");
        e &= ~(B_V33 | B_V5); push(7, 28, "R9 rails off");
        pg_main = 0; sleep3_req_n = 0;
        wait_st(7);
        repeat (10) @(negedge clk);
        check("R8 scoreboard drained", q.size(), 0);
        check("R10 stays in S3", {15'd0, state_oh}, 32'd1 << 7);
        check("R9 final outputs", {22'd0, outs}, {22'd0, e});
        finish_run();
    end
endmodule